// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Aspect Ratio

This block is a true dual-port synchronous RAM with 4608 bits of storage. Its two ports, A and B, each have their own clock, an active-low port enable, an active-low write enable, a 12-bit address, 9-bit write data and 9-bit read data. A parameter fixes each port's shape to one of four: 4096 entries of 1 bit, 2048 of 2 bits, 1024 of 4 bits or 512 of 9 bits. The two ports may have different shapes and still see the same stored bits. They reach those bits through different address mappings.

The storage is organised as 512 words of 9 bits. The three narrow shapes address only the low 8 bits of each word. The low address bits pick the field inside the word, and the bits above them pick the word. In the 9-bit shape every bit of the word is reachable, so bit 8 exists only for a port set to that shape.

Each port has two run-time selects. The pipeline select adds one output register after the read. The pass-through select decides what the output shows during a write. A synchronous, active-high reset clears the output registers of both ports and blocks all accesses while it is held. It leaves the stored contents as they were. The block is used as a shared buffer between two clock domains. It can also serve as a width converter, for example with a narrow writer on one port and a wide reader on the other.

Top module: `dual_aspect_ram`

## Requirements
- R1: On a port's clock edge with `rst` high, that port's two output registers are set to zero and no read or write takes place. `dout` is zero on the first edge after `rst` falls.
- R2: The shape code is a 2-bit parameter: 00 selects 4096×1, 01 selects 2048×2, 10 selects 1024×4 and 11 selects 512×9. For a narrow shape with field width w (1, 2 or 4 bits), the word index is `addr / (8/w)`, and the field starts at bit `(addr % (8/w))*w` of that word. The unused high address bits (above bit 11, 10 or 9 for the narrow shapes) are held at zero.
- R3: In the 512×9 shape, `addr[8:0]` selects a word and all 9 bits are read and written. A narrow write leaves bit 8 and the other fields of the word unchanged. Narrow read data is placed in the low bits of `dout`, and the bits above the field width are zero.
- R4: While `en_n` is high, the port performs no access, its output registers hold, and `dout` stays constant for as long as `pipe` is unchanged.
- R5: A read (`en_n` low, `we_n` high) with `pipe` low shows the addressed field on `dout` just after the access edge.
- R6: With `pipe` high, `dout` shows a second register. On each enabled edge, this second register loads the value the first register held before that edge, so read data appears one enabled edge later.
- R7: During a write (`en_n` low, `we_n` low), `thru` high loads the written data, masked to the field width, into the output register. `thru` low leaves the output register unchanged. `thru` has no effect on a read.
- R8: The stored contents keep their values while `rst` is held and after it is released.
- R9: A read on one port returns the contents from before the edge, even when the other port writes the same word on that edge. Both ports writing the same 9-bit word on the same edge is not allowed, and the stored result of doing so is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst | input | 1 | Synchronous reset, active high, sampled by each port's clock |
| en_n_a | input | 1 | Port A enable, active low |
| we_n_a | input | 1 | Port A write enable, active low (high = read) |
| pipe_a | input | 1 | Port A pipelined-read select |
| thru_a | input | 1 | Port A write pass-through select |
| addr_a | input | 12 | Port A address |
| din_a | input | 9 | Port A write data (low w bits used in narrow shapes) |
| dout_a | output | 9 | Port A read data |
| en_n_b | input | 1 | Port B enable, active low |
| we_n_b | input | 1 | Port B write enable, active low (high = read) |
| pipe_b | input | 1 | Port B pipelined-read select |
| thru_b | input | 1 | Port B write pass-through select |
| addr_b | input | 12 | Port B address |
| din_b | input | 9 | Port B write data (low w bits used in narrow shapes) |
| dout_b | output | 9 | Port B read data |

## Verification
The assertions check, on every edge, the per-port output behaviour that follows from the inputs alone:
- the output holds while the port is disabled;
- the output holds during a non-pass-through write;
- the written data appears during a pass-through write;
- the outputs are zero right after reset;
- the two ports never write the same word on the same edge.

Only the bench scenarios can show behaviour that depends on the stored contents, which they compare against an independent reference memory:
- the address mapping between two ports of different shapes;
- that bit 8 and the neighbouring fields survive narrow writes;
- the one-edge delay of pipelined reads;
- read-before-write ordering between the ports;
- that the contents survive a reset during which writes were attempted.

// File: rtl/dar_pkg.sv
package dar_pkg;

    localparam int WORDS    = 512;
    localparam int WORD_W   = 9;
    localparam int ADDR_W   = 12;
    localparam int IDX_W    = $clog2(WORDS);
    localparam int LSB_W    = 4;

    typedef enum logic [1:0] {
        SHAPE_X1 = 2'b00,
        SHAPE_X2 = 2'b01,
        SHAPE_X4 = 2'b10,
        SHAPE_X9 = 2'b11
    } shape_e;

    typedef struct packed {
        logic [IDX_W-1:0]  word;
        logic [LSB_W-1:0]  lsb;
        logic [WORD_W-1:0] mask;
    } slot_t;

    // Word index selected by an address for a given shape.
    function automatic logic [IDX_W-1:0] word_index(logic [1:0] shape, logic [ADDR_W-1:0] a);
        logic [IDX_W-1:0] w;
        case (shape_e'(shape))
            SHAPE_X1: w = a[11:3];
            SHAPE_X2: w = a[10:2];
            SHAPE_X4: w = a[9:1];
            default:  w = a[8:0];
        endcase
        return w;
    endfunction

    // Mask of the field bits that one access of the shape covers, right aligned.
    function automatic logic [WORD_W-1:0] low_mask(logic [1:0] shape);
        logic [WORD_W-1:0] m;
        case (shape_e'(shape))
            SHAPE_X1: m = 9'h001;
            SHAPE_X2: m = 9'h003;
            SHAPE_X4: m = 9'h00F;
            default:  m = 9'h1FF;
        endcase
        return m;
    endfunction

    // Full placement of an access inside the storage word.
    function automatic slot_t map_addr(logic [1:0] shape, logic [ADDR_W-1:0] a);
        slot_t s;
        s.word = word_index(shape, a);
        case (shape_e'(shape))
            SHAPE_X1: s.lsb = {1'b0, a[2:0]};
            SHAPE_X2: s.lsb = {1'b0, a[1:0], 1'b0};
            SHAPE_X4: s.lsb = {1'b0, a[0], 2'b00};
            default:  s.lsb = '0;
        endcase
        s.mask = low_mask(shape) << s.lsb;
        return s;
    endfunction

    // Field of a word, right aligned and zero extended.
    function automatic logic [WORD_W-1:0] pick(slot_t s, logic [WORD_W-1:0] w);
        return (w & s.mask) >> s.lsb;
    endfunction

    // Word with the field replaced by new data.
    function automatic logic [WORD_W-1:0] place(slot_t s, logic [WORD_W-1:0] old,
                                                logic [WORD_W-1:0] d);
        return (old & ~s.mask) | ((d << s.lsb) & s.mask);
    endfunction

endpackage

// File: rtl/dar_bank.sv
// One storage bank with a single writer and two asynchronous read taps.
module dar_bank #(
    parameter int DEPTH = dar_pkg::WORDS,
    parameter int DW    = dar_pkg::WORD_W,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ridx_a,
    input  logic [AW-1:0] ridx_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata_a = mem[ridx_a];
    assign rdata_b = mem[ridx_b];

endmodule

// File: rtl/dar_port.sv
// Access decode and output registers of one port.
module dar_port
    import dar_pkg::*;
#(
    parameter logic [1:0] SHAPE = 2'b00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              we_n,
    input  logic              pipe,
    input  logic              thru,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    input  logic [WORD_W-1:0] word_now,
    output logic [IDX_W-1:0]  idx,
    output logic              wr_go,
    output logic [WORD_W-1:0] word_new,
    output logic [WORD_W-1:0] dout
);

    localparam logic [WORD_W-1:0] FIELD_MASK = low_mask(SHAPE);

    slot_t             slot;
    logic [WORD_W-1:0] core_q;
    logic [WORD_W-1:0] pipe_q;

    assign slot     = map_addr(SHAPE, addr);
    assign idx      = slot.word;
    assign wr_go    = !rst && !en_n && !we_n;
    assign word_new = place(slot, word_now, din);

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
            pipe_q <= '0;
        end else if (!en_n) begin
            pipe_q <= core_q;
            if (we_n) begin
                core_q <= pick(slot, word_now);
            end else if (thru) begin
                core_q <= din & FIELD_MASK;
            end
        end
    end

    assign dout = pipe ? pipe_q : core_q;

endmodule

// File: rtl/dual_aspect_ram.sv
// Dual-port RAM; each port writes its own bank and the stored word is the XOR of both.
module dual_aspect_ram
    import dar_pkg::*;
#(
    parameter logic [1:0] SHAPE_A = 2'b00,
    parameter logic [1:0] SHAPE_B = 2'b10
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              rst,
    input  logic              en_n_a,
    input  logic              we_n_a,
    input  logic              pipe_a,
    input  logic              thru_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [WORD_W-1:0] din_a,
    output logic [WORD_W-1:0] dout_a,
    input  logic              en_n_b,
    input  logic              we_n_b,
    input  logic              pipe_b,
    input  logic              thru_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [WORD_W-1:0] din_b,
    output logic [WORD_W-1:0] dout_b
);

    logic [IDX_W-1:0]  idx_a, idx_b;
    logic              go_a, go_b;
    logic [WORD_W-1:0] new_a, new_b;
    logic [WORD_W-1:0] ba_at_a, ba_at_b, bb_at_a, bb_at_b;
    logic [WORD_W-1:0] word_at_a, word_at_b;

    assign word_at_a = ba_at_a ^ bb_at_a;
    assign word_at_b = ba_at_b ^ bb_at_b;

    dar_port #(.SHAPE(SHAPE_A)) u_port_a (
        .clk      (clk_a),
        .rst      (rst),
        .en_n     (en_n_a),
        .we_n     (we_n_a),
        .pipe     (pipe_a),
        .thru     (thru_a),
        .addr     (addr_a),
        .din      (din_a),
        .word_now (word_at_a),
        .idx      (idx_a),
        .wr_go    (go_a),
        .word_new (new_a),
        .dout     (dout_a)
    );

    dar_port #(.SHAPE(SHAPE_B)) u_port_b (
        .clk      (clk_b),
        .rst      (rst),
        .en_n     (en_n_b),
        .we_n     (we_n_b),
        .pipe     (pipe_b),
        .thru     (thru_b),
        .addr     (addr_b),
        .din      (din_b),
        .word_now (word_at_b),
        .idx      (idx_b),
        .wr_go    (go_b),
        .word_new (new_b),
        .dout     (dout_b)
    );

    dar_bank #(.DEPTH(WORDS), .DW(WORD_W)) u_bank_a (
        .clk     (clk_a),
        .we      (go_a),
        .widx    (idx_a),
        .wdata   (new_a ^ bb_at_a),
        .ridx_a  (idx_a),
        .ridx_b  (idx_b),
        .rdata_a (ba_at_a),
        .rdata_b (ba_at_b)
    );

    dar_bank #(.DEPTH(WORDS), .DW(WORD_W)) u_bank_b (
        .clk     (clk_b),
        .we      (go_b),
        .widx    (idx_b),
        .wdata   (new_b ^ ba_at_b),
        .ridx_a  (idx_a),
        .ridx_b  (idx_b),
        .rdata_a (bb_at_a),
        .rdata_b (bb_at_b)
    );

endmodule

// File: rtl/dar_checker.sv
module dar_checker
    import dar_pkg::*;
#(
    parameter logic [1:0] SHAPE_A = 2'b00,
    parameter logic [1:0] SHAPE_B = 2'b10
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              rst,
    input logic              en_n_a,
    input logic              we_n_a,
    input logic              pipe_a,
    input logic              thru_a,
    input logic [ADDR_W-1:0] addr_a,
    input logic [WORD_W-1:0] din_a,
    input logic [WORD_W-1:0] dout_a,
    input logic              en_n_b,
    input logic              we_n_b,
    input logic              pipe_b,
    input logic              thru_b,
    input logic [ADDR_W-1:0] addr_b,
    input logic [WORD_W-1:0] din_b,
    input logic [WORD_W-1:0] dout_b
);

    localparam logic [WORD_W-1:0] MASK_A = low_mask(SHAPE_A);
    localparam logic [WORD_W-1:0] MASK_B = low_mask(SHAPE_B);

    logic [IDX_W-1:0] w_a, w_b;
    assign w_a = word_index(SHAPE_A, addr_a);
    assign w_b = word_index(SHAPE_B, addr_b);

    AST_RESET_CLEARS_A: assert property (@(posedge clk_a) disable iff (rst)
        $fell(rst) |-> (dout_a == '0));                                          // R1
    AST_RESET_CLEARS_B: assert property (@(posedge clk_b) disable iff (rst)
        $fell(rst) |-> (dout_b == '0));                                          // R1
    AST_HOLD_WHEN_OFF_A: assert property (@(posedge clk_a) disable iff (rst)
        en_n_a |=> ($stable(dout_a) || !$stable(pipe_a)));                       // R4
    AST_HOLD_WHEN_OFF_B: assert property (@(posedge clk_b) disable iff (rst)
        en_n_b |=> ($stable(dout_b) || !$stable(pipe_b)));                       // R4
    AST_WRITE_HOLDS_A: assert property (@(posedge clk_a) disable iff (rst)
        (!en_n_a && !we_n_a && !thru_a && !pipe_a)
        |=> ($stable(dout_a) || !$stable(pipe_a)));                              // R7
    AST_WRITE_HOLDS_B: assert property (@(posedge clk_b) disable iff (rst)
        (!en_n_b && !we_n_b && !thru_b && !pipe_b)
        |=> ($stable(dout_b) || !$stable(pipe_b)));                              // R7
    AST_WRITE_THRU_A: assert property (@(posedge clk_a) disable iff (rst)
        (!en_n_a && !we_n_a && thru_a)
        |=> (pipe_a || dout_a == ($past(din_a) & MASK_A)));                      // R7
    AST_WRITE_THRU_B: assert property (@(posedge clk_b) disable iff (rst)
        (!en_n_b && !we_n_b && thru_b)
        |=> (pipe_b || dout_b == ($past(din_b) & MASK_B)));                      // R7
    AST_NO_WORD_CLASH: assert property (@(posedge clk_a) disable iff (rst)
        (!en_n_a && !we_n_a && !en_n_b && !we_n_b) |-> (w_a != w_b));            // R9

endmodule

bind dual_aspect_ram dar_checker #(.SHAPE_A(SHAPE_A), .SHAPE_B(SHAPE_B)) u_dar_checker (
    .clk_a  (clk_a),
    .clk_b  (clk_b),
    .rst    (rst),
    .en_n_a (en_n_a),
    .we_n_a (we_n_a),
    .pipe_a (pipe_a),
    .thru_a (thru_a),
    .addr_a (addr_a),
    .din_a  (din_a),
    .dout_a (dout_a),
    .en_n_b (en_n_b),
    .we_n_b (we_n_b),
    .pipe_b (pipe_b),
    .thru_b (thru_b),
    .addr_b (addr_b),
    .din_b  (din_b),
    .dout_b (dout_b)
);

// File: tb/dual_aspect_ram_bench.sv
`timescale 1ns/1ps
module dual_aspect_ram_bench;

    localparam int NCFG = 2;
    // cfg0: A 4096x1, B 1024x4   cfg1: A 512x9, B 2048x2
    localparam logic [NCFG-1:0][1:0] SA = {2'b11, 2'b00};
    localparam logic [NCFG-1:0][1:0] SB = {2'b01, 2'b10};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        en_n [NCFG][2];
    logic        we_n [NCFG][2];
    logic        pipe [NCFG][2];
    logic        thru [NCFG][2];
    logic [11:0] addr [NCFG][2];
    logic [8:0]  din  [NCFG][2];
    logic [8:0]  dout [NCFG][2];
    string       tag  [NCFG][2];

    for (genvar c = 0; c < NCFG; c++) begin : g_cfg
        dual_aspect_ram #(.SHAPE_A(SA[c]), .SHAPE_B(SB[c])) u_dual_aspect_ram (
            .clk_a (clk), .clk_b (clk), .rst (rst),
            .en_n_a (en_n[c][0]), .we_n_a (we_n[c][0]), .pipe_a (pipe[c][0]),
            .thru_a (thru[c][0]), .addr_a (addr[c][0]), .din_a (din[c][0]),
            .dout_a (dout[c][0]),
            .en_n_b (en_n[c][1]), .we_n_b (we_n[c][1]), .pipe_b (pipe[c][1]),
            .thru_b (thru[c][1]), .addr_b (addr[c][1]), .din_b (din[c][1]),
            .dout_b (dout[c][1])
        );
    end

    // Reference state
    logic [8:0] ref_mem [NCFG][512];
    logic [8:0] mcore [NCFG][2];
    logic [8:0] mpipe [NCFG][2];

    typedef struct {
        int         due;
        int         c;
        int         p;
        logic [8:0] exp;
        string      req;
    } sb_t;
    sb_t sbq [$];

    int  cyc   = 0;
    int  nchk  = 0;
    int  nfail = 0;
    bit  done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [1:0] shape_of(int c, int p);
        return (p == 0) ? SA[c] : SB[c];
    endfunction
    function automatic int bits_of(logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 4;
            default: return 9;
        endcase
    endfunction
    function automatic int word_of(logic [1:0] s, logic [11:0] a);
        int b = bits_of(s);
        if (b == 9) return int'(a[8:0]);
        return (int'(a) / (8 / b)) % 512;
    endfunction
    function automatic int off_of(logic [1:0] s, logic [11:0] a);
        int b = bits_of(s);
        if (b == 9) return 0;
        return (int'(a) % (8 / b)) * b;
    endfunction
    function automatic logic [8:0] fmask(logic [1:0] s);
        return 9'((1 << bits_of(s)) - 1);
    endfunction

    function automatic logic [8:0] ref_read(int c, logic [1:0] s, logic [11:0] a);
        logic [8:0] v = '0;
        int w = word_of(s, a);
        int o = off_of(s, a);
        for (int k = 0; k < bits_of(s); k++) v[k] = ref_mem[c][w][o + k];
        return v;
    endfunction

    task automatic ref_write(int c, logic [1:0] s, logic [11:0] a, logic [8:0] d);
        int w = word_of(s, a);
        int o = off_of(s, a);
        for (int k = 0; k < bits_of(s); k++) ref_mem[c][w][o + k] = d[k];
    endtask

    task automatic set(int c, int p, bit acc, bit wr, logic [11:0] a, logic [8:0] d,
                       bit th, string t);
        en_n[c][p] = !acc;
        we_n[c][p] = !wr;
        addr[c][p] = a;
        din[c][p]  = d;
        thru[c][p] = th;
        tag[c][p]  = t;
    endtask

    // Driver: model the coming edge, queue the expected outputs, then advance.
    task automatic tick();
        logic [8:0] rdv [NCFG][2];
        for (int c = 0; c < NCFG; c++)
            for (int p = 0; p < 2; p++)
                rdv[c][p] = ref_read(c, shape_of(c, p), addr[c][p]);
        for (int c = 0; c < NCFG; c++) begin
            for (int p = 0; p < 2; p++) begin
                if (rst) begin
                    mcore[c][p] = '0;
                    mpipe[c][p] = '0;
                end else if (!en_n[c][p]) begin
                    mpipe[c][p] = mcore[c][p];
                    if (we_n[c][p]) begin
                        mcore[c][p] = rdv[c][p];
                    end else begin
                        if (thru[c][p]) mcore[c][p] = din[c][p] & fmask(shape_of(c, p));
                        ref_write(c, shape_of(c, p), addr[c][p], din[c][p]);
                    end
                end
            end
        end
        for (int c = 0; c < NCFG; c++) begin
            for (int p = 0; p < 2; p++) begin
                sb_t it;
                it.due = cyc + 1;
                it.c   = c;
                it.p   = p;
                it.exp = pipe[c][p] ? mpipe[c][p] : mcore[c][p];
                it.req = tag[c][p];
                sbq.push_back(it);
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCFG; c++)
            for (int p = 0; p < 2; p++) begin
                en_n[c][p] = 1'b1;
                tag[c][p]  = "R4";
            end
    endtask

    // Monitor: compare after each edge, well before the next input change.
    always @(posedge clk) begin
        #1;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            sb_t it;
            it = sbq.pop_front();
            nchk++;
            if (dout[it.c][it.p] !== it.exp) begin
                nfail++;
                $display("FAIL %s cfg%0d port%0d: dout=%h expected=%h (cycle %0d)",
                         it.req, it.c, it.p, dout[it.c][it.p], it.exp, cyc);
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R1 watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCFG; c++) begin
            for (int w = 0; w < 512; w++) ref_mem[c][w] = '0;
            for (int p = 0; p < 2; p++) begin
                mcore[c][p] = '0;
                mpipe[c][p] = '0;
                pipe[c][p]  = 1'b0;
                set(c, p, 0, 0, '0, '0, 0, "R1");
            end
        end
        @(negedge clk);

        // R1: reset state
        for (int c = 0; c < NCFG; c++) for (int p = 0; p < 2; p++) tag[c][p] = "R1";
        repeat (3) begin
            for (int c = 0; c < NCFG; c++) for (int p = 0; p < 2; p++) tag[c][p] = "R1";
            tick();
        end
        rst = 1'b0;

        // Preload: cfg0 through the 1024x4 port, cfg1 through the 512x9 port
        for (int i = 0; i < 32; i++) begin
            set(0, 1, 1, 1, 12'(i), 9'((i * 7 + 3) & 15), 0, "R2");
            if (i < 16) set(1, 0, 1, 1, 12'(i), 9'(9'h1A5 ^ (i * 37)), 0, "R3");
            tick();
        end

        // R2 / R3: cross-shape reads
        for (int i = 0; i < 64; i++) begin
            set(0, 0, 1, 0, 12'(i), '0, 0, "R2");
            set(0, 1, 1, 0, 12'(i % 32), '0, 0, "R5");
            set(1, 1, 1, 0, 12'(i), '0, 0, "R3");
            set(1, 0, 1, 0, 12'(i % 16), '0, 0, "R3");
            tick();
        end

        // R3: narrow writes keep bit 8 and neighbours; wide read back
        set(1, 1, 1, 1, 12'd9, 9'h1FE, 0, "R3");
        set(0, 0, 1, 1, 12'd13, 9'h001, 0, "R2");
        tick();
        set(1, 0, 1, 0, 12'd2, '0, 0, "R3");
        set(0, 1, 1, 0, 12'd3, '0, 0, "R2");
        tick();

        // R7: pass-through write, then holding write
        set(0, 0, 1, 1, 12'd7, 9'h1FF, 1, "R7");
        set(0, 1, 1, 1, 12'd20, 9'h0FC, 1, "R7");
        set(1, 0, 1, 1, 12'd5, 9'h155, 1, "R7");
        set(1, 1, 1, 1, 12'd40, 9'h0F2, 1, "R7");
        tick();
        set(0, 0, 1, 0, 12'd14, '0, 0, "R5");
        set(0, 1, 1, 0, 12'd21, '0, 0, "R5");
        set(1, 0, 1, 0, 12'd6, '0, 1, "R7");
        set(1, 1, 1, 0, 12'd41, '0, 1, "R7");
        tick();
        set(0, 0, 1, 1, 12'd6, 9'h000, 0, "R7");
        set(0, 1, 1, 1, 12'd22, 9'h00A, 0, "R7");
        set(1, 0, 1, 1, 12'd7, 9'h0AA, 0, "R7");
        set(1, 1, 1, 1, 12'd42, 9'h001, 0, "R7");
        tick();

        // R4: disabled port with write strobe set leaves memory and output alone
        for (int k = 0; k < 3; k++) begin
            set(0, 0, 0, 1, 12'd6, 9'h1FF, 1, "R4");
            set(0, 1, 0, 1, 12'd22, 9'h005, 1, "R4");
            set(1, 0, 0, 1, 12'd7, 9'h000, 1, "R4");
            set(1, 1, 0, 1, 12'd42, 9'h002, 1, "R4");
            tick();
        end
        set(0, 0, 1, 0, 12'd6, '0, 0, "R4");
        set(0, 1, 1, 0, 12'd22, '0, 0, "R4");
        set(1, 0, 1, 0, 12'd7, '0, 0, "R4");
        set(1, 1, 1, 0, 12'd42, '0, 0, "R4");
        tick();

        // R6: pipelined reads
        for (int c = 0; c < NCFG; c++) for (int p = 0; p < 2; p++) pipe[c][p] = 1'b1;
        for (int i = 0; i < 8; i++) begin
            set(0, 0, 1, 0, 12'(i * 5), '0, 0, "R6");
            set(0, 1, 1, 0, 12'(i * 3), '0, 0, "R6");
            set(1, 0, 1, 0, 12'(15 - i), '0, 0, "R6");
            set(1, 1, 1, 0, 12'(i * 7), '0, 0, "R6");
            tick();
        end
        tick();
        for (int c = 0; c < NCFG; c++) for (int p = 0; p < 2; p++) pipe[c][p] = 1'b0;
        tick();

        // R9: read of a word written by the other port on the same edge returns old data
        set(1, 0, 1, 1, 12'd3, 9'h0F0, 0, "R9");
        set(1, 1, 1, 0, 12'd12, '0, 0, "R9");
        set(0, 1, 1, 1, 12'd0, 9'h009, 0, "R9");
        set(0, 0, 1, 0, 12'd1, '0, 0, "R9");
        tick();
        set(1, 1, 1, 0, 12'd13, '0, 0, "R9");
        set(0, 0, 1, 0, 12'd3, '0, 0, "R9");
        tick();

        // R1 / R8: writes attempted during reset are blocked; contents survive
        rst = 1'b1;
        set(0, 0, 1, 1, 12'd8, 9'h001, 1, "R1");
        set(0, 1, 1, 1, 12'd4, 9'h00F, 1, "R1");
        set(1, 0, 1, 1, 12'd10, 9'h000, 1, "R1");
        set(1, 1, 1, 1, 12'd44, 9'h003, 1, "R1");
        tick();
        for (int c = 0; c < NCFG; c++) for (int p = 0; p < 2; p++) tag[c][p] = "R1";
        tick();
        rst = 1'b0;
        for (int c = 0; c < NCFG; c++) for (int p = 0; p < 2; p++) tag[c][p] = "R1";
        tick();
        for (int i = 0; i < 8; i++) begin
            set(0, 0, 1, 0, 12'(8 + i), '0, 0, "R8");
            set(0, 1, 1, 0, 12'(4 + i), '0, 0, "R8");
            set(1, 0, 1, 0, 12'(10 + i % 6), '0, 0, "R8");
            set(1, 1, 1, 0, 12'(40 + i), '0, 0, "R8");
            tick();
        end

        repeat (3) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule